// File: doc/BRIEF.md
# Teletext Page Request Matcher

This block holds the page requests of four acquisition circuits and decides, header by header, which circuit captures the page that follows. Software fills a request table one byte at a time. It first loads a start column and a circuit number, and each data write then advances the column. After the last column the pointer moves on to column 0 of the next circuit.

The block receives one header per pulse of `hdr_valid_i`. The header has already been Hamming-decoded and arrives as magazine, page tens and units, and hour and minute sub-code digits. Each digit comes with its own error flag. Every circuit compares the header with its own request. Only the digits whose do-care bit is set take part in the comparison, so one table can ask for a normal page or for a timed page.

A circuit that matches asserts its capture enable. The enable stays high until the next error-free header of the same magazine arrives. A found flag (active low) and a looking flag report the progress of the search. A hold bit can freeze a circuit: while it is low, the page already captured is kept and no new capture begins.

Top module: `ttx_page_matcher`

## Requirements
- R1: After reset `capture_o` is 0, `found_n_o` is all ones, `looking_o` is 0, and every table byte is 0. A zero table has no do-care bit and its hold bit is low, so no header causes a capture.
- R2: A pulse on `req_addr_we_i` loads the write pointer with column `req_col_i` and circuit `req_circ_i`. Each `req_data_we_i` stores the byte at the pointer and then moves the pointer. From columns 0 to 5 it moves to the next column. From column 6 or 7 it moves to column 0 of the next circuit, and the circuit number wraps modulo NUM_CIRC. A write at column 7 stores nothing.
- R3: The table has seven columns per circuit. Column 0 holds the magazine in bits 2:0. Column 1 holds page tens and column 2 page units, both in bits 3:0. Column 3 holds hours tens in bits 1:0 and column 4 hours units in bits 3:0. Column 5 holds minutes tens in bits 2:0 and column 6 minutes units in bits 3:0. Bit 4 of each column is its do-care flag. A digit is compared only when its do-care flag is 1.
- R4: Bit 3 of column 0 is the hold flag. When it is 1, a matching header starts a capture. When it is 0, no capture starts. A data write to column 0 with the hold flag at 0 also ends the current capture and clears `looking_o`, while `found_n_o` keeps its value.
- R5: A digit that is compared and has its error flag set makes the header a non-match. An error flag on a digit that is not compared has no effect. The error flags map to the digits by bit: 0 magazine, 1 page tens, 2 page units, 3 hours tens, 4 hours units, 5 minutes tens, 6 minutes units.
- R6: A matching header with the hold flag at 1 sets `capture_o` for that circuit in the cycle after the header. The circuit also records the header's magazine. The enable stays set while headers of other magazines arrive. It clears after the next header of the recorded magazine that does not match again.
- R7: When a capture starts, `found_n_o` goes to 0 and `looking_o` goes to 0. A data write to column 0 with the hold flag at 1 restarts the search: `looking_o` goes to 1, `found_n_o` goes to 1 and `capture_o` goes to 0. A write to column 0 takes priority over a header arriving in the same cycle.
- R8: All circuits compare the same header in parallel, and one header can start a capture on several circuits in the same cycle.
- R9: A header whose magazine error flag is set changes no capture, found or looking state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_we_i | input | 1 | Load the write pointer |
| req_col_i | input | 3 | Start column |
| req_circ_i | input | CIRC_W | Circuit select |
| req_data_we_i | input | 1 | Write one request byte |
| req_data_i | input | 8 | Request byte |
| hdr_valid_i | input | 1 | Header present, one cycle |
| hdr_mag_i | input | 3 | Magazine |
| hdr_pt_i | input | 4 | Page tens |
| hdr_pu_i | input | 4 | Page units |
| hdr_ht_i | input | 2 | Hours tens |
| hdr_hu_i | input | 4 | Hours units |
| hdr_mt_i | input | 3 | Minutes tens |
| hdr_mu_i | input | 4 | Minutes units |
| hdr_err_i | input | 7 | Error flag per digit |
| capture_o | output | NUM_CIRC | Capture enable per circuit |
| found_n_o | output | NUM_CIRC | Low once the page has been found |
| looking_o | output | NUM_CIRC | Page being looked for |

## Verification
Every result is due one clock after its cause. A header or a table write that is sampled on a rising edge shows up on `capture_o`, `found_n_o` and `looking_o` right after that edge. A header that arrives in the cycle after a table write already sees the new byte.

The bench drives its inputs on the falling edge and holds them for one cycle. It updates a behavioural model on the same rising edge as the design. It compares all three outputs with the model on the next falling edge, and it makes its directed checks at that falling edge as well.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  localparam int NUM_COLS = 7;
  localparam int COL_W    = 3;
  localparam int BYTE_W   = 8;

  // error flag index per digit
  localparam int E_MAG = 0;
  localparam int E_PT  = 1;
  localparam int E_PU  = 2;
  localparam int E_HT  = 3;
  localparam int E_HU  = 4;
  localparam int E_MT  = 5;
  localparam int E_MU  = 6;

  typedef struct packed {
    logic [2:0] mag;
    logic [3:0] pt;
    logic [3:0] pu;
    logic [1:0] ht;
    logic [3:0] hu;
    logic [2:0] mt;
    logic [3:0] mu;
  } hdr_t;

  typedef struct packed {
    logic [NUM_COLS-1:0] care;
    logic                hold;
    hdr_t                dig;
  } req_t;
endpackage

// File: rtl/ttx_req_table.sv
module ttx_req_table
  import ttx_pkg::*;
#(
  parameter int NUM_CIRC = 4,
  parameter int CIRC_W   = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   addr_we_i,
  input  logic [COL_W-1:0]       addr_col_i,
  input  logic [CIRC_W-1:0]      addr_circ_i,
  input  logic                   data_we_i,
  input  logic [BYTE_W-1:0]      data_i,
  output req_t [NUM_CIRC-1:0]    req_o,
  output logic [NUM_CIRC-1:0]    restart_o,
  output logic [NUM_CIRC-1:0]    freeze_o
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [CIRC_W-1:0] LAST_CIRC = CIRC_W'(NUM_CIRC - 1);

  logic [COL_W-1:0]  col_q;
  logic [CIRC_W-1:0] circ_q;
  logic              unused_hi;

  assign unused_hi = ^data_i[BYTE_W-1:5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      circ_q <= '0;
    end else if (addr_we_i) begin
      col_q  <= addr_col_i;
      circ_q <= addr_circ_i;
    end else if (data_we_i) begin
      if (col_q >= LAST_COL) begin
        col_q  <= '0;
        circ_q <= (circ_q == LAST_CIRC) ? '0 : circ_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  for (genvar c = 0; c < NUM_CIRC; c++) begin : g_circ
    logic       hit;
    logic [4:0] c0_q, c1_q, c2_q, c4_q, c6_q;
    logic [2:0] c3_q;
    logic [3:0] c5_q;

    assign hit = data_we_i && (circ_q == CIRC_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c0_q <= '0; c1_q <= '0; c2_q <= '0; c3_q <= '0;
        c4_q <= '0; c5_q <= '0; c6_q <= '0;
      end else if (hit) begin
        case (col_q)
          3'd0: c0_q <= data_i[4:0];
          3'd1: c1_q <= data_i[4:0];
          3'd2: c2_q <= data_i[4:0];
          3'd3: c3_q <= {data_i[4], data_i[1:0]};
          3'd4: c4_q <= data_i[4:0];
          3'd5: c5_q <= {data_i[4], data_i[2:0]};
          3'd6: c6_q <= data_i[4:0];
          default: ;
        endcase
      end
    end

    assign req_o[c].care     = {c6_q[4], c5_q[3], c4_q[4], c3_q[2], c2_q[4], c1_q[4], c0_q[4]};
    assign req_o[c].hold     = c0_q[3];
    assign req_o[c].dig.mag  = c0_q[2:0];
    assign req_o[c].dig.pt   = c1_q[3:0];
    assign req_o[c].dig.pu   = c2_q[3:0];
    assign req_o[c].dig.ht   = c3_q[1:0];
    assign req_o[c].dig.hu   = c4_q[3:0];
    assign req_o[c].dig.mt   = c5_q[2:0];
    assign req_o[c].dig.mu   = c6_q[3:0];

    assign restart_o[c] = hit && (col_q == '0) &&  data_i[3];
    assign freeze_o[c]  = hit && (col_q == '0) && !data_i[3];
  end
endmodule

// File: rtl/ttx_digit_cmp.sv
module ttx_digit_cmp
  import ttx_pkg::*;
(
  input  req_t                req_i,
  input  hdr_t                hdr_i,
  input  logic [NUM_COLS-1:0] err_i,
  output logic                match_o
);
  logic [NUM_COLS-1:0] eq;

  always_comb begin
    eq        = '0;
    eq[E_MAG] = req_i.dig.mag == hdr_i.mag;
    eq[E_PT]  = req_i.dig.pt  == hdr_i.pt;
    eq[E_PU]  = req_i.dig.pu  == hdr_i.pu;
    eq[E_HT]  = req_i.dig.ht  == hdr_i.ht;
    eq[E_HU]  = req_i.dig.hu  == hdr_i.hu;
    eq[E_MT]  = req_i.dig.mt  == hdr_i.mt;
    eq[E_MU]  = req_i.dig.mu  == hdr_i.mu;
  end

  // uncared digits pass, cared digits need equality and a clean nibble
  assign match_o = &(~req_i.care | (eq & ~err_i));
endmodule

// File: rtl/ttx_capture_ctl.sv
module ttx_capture_ctl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hdr_valid_i,
  input  logic [2:0] hdr_mag_i,
  input  logic       mag_err_i,
  input  logic       match_i,
  input  logic       hold_i,
  input  logic       restart_i,
  input  logic       freeze_i,
  output logic       capture_o,
  output logic       found_n_o,
  output logic       looking_o
);
  logic [2:0] cap_mag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      capture_o <= 1'b0;
      found_n_o <= 1'b1;
      looking_o <= 1'b0;
      cap_mag_q <= '0;
    end else if (restart_i) begin
      capture_o <= 1'b0;
      found_n_o <= 1'b1;
      looking_o <= 1'b1;
    end else if (freeze_i) begin
      capture_o <= 1'b0;
      looking_o <= 1'b0;
    end else if (hdr_valid_i && !mag_err_i) begin
      if (match_i && hold_i) begin
        capture_o <= 1'b1;
        cap_mag_q <= hdr_mag_i;
        found_n_o <= 1'b0;
        looking_o <= 1'b0;
      end else if (capture_o && hdr_mag_i == cap_mag_q) begin
        capture_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ttx_page_matcher.sv
module ttx_page_matcher
  import ttx_pkg::*;
#(
  parameter int NUM_CIRC = 4,
  parameter int CIRC_W   = $clog2(NUM_CIRC)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_addr_we_i,
  input  logic [2:0]          req_col_i,
  input  logic [CIRC_W-1:0]   req_circ_i,
  input  logic                req_data_we_i,
  input  logic [7:0]          req_data_i,
  input  logic                hdr_valid_i,
  input  logic [2:0]          hdr_mag_i,
  input  logic [3:0]          hdr_pt_i,
  input  logic [3:0]          hdr_pu_i,
  input  logic [1:0]          hdr_ht_i,
  input  logic [3:0]          hdr_hu_i,
  input  logic [2:0]          hdr_mt_i,
  input  logic [3:0]          hdr_mu_i,
  input  logic [6:0]          hdr_err_i,
  output logic [NUM_CIRC-1:0] capture_o,
  output logic [NUM_CIRC-1:0] found_n_o,
  output logic [NUM_CIRC-1:0] looking_o
);
  req_t [NUM_CIRC-1:0] req;
  logic [NUM_CIRC-1:0] restart, freeze;
  hdr_t                hdr;

  assign hdr = '{mag: hdr_mag_i, pt: hdr_pt_i, pu: hdr_pu_i, ht: hdr_ht_i,
                 hu: hdr_hu_i, mt: hdr_mt_i, mu: hdr_mu_i};

  ttx_req_table #(.NUM_CIRC(NUM_CIRC), .CIRC_W(CIRC_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_we_i  (req_addr_we_i),
    .addr_col_i (req_col_i),
    .addr_circ_i(req_circ_i),
    .data_we_i  (req_data_we_i),
    .data_i     (req_data_i),
    .req_o      (req),
    .restart_o  (restart),
    .freeze_o   (freeze)
  );

  for (genvar c = 0; c < NUM_CIRC; c++) begin : g_circ
    logic match;

    ttx_digit_cmp u_cmp (
      .req_i  (req[c]),
      .hdr_i  (hdr),
      .err_i  (hdr_err_i),
      .match_o(match)
    );

    ttx_capture_ctl u_ctl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hdr_valid_i(hdr_valid_i),
      .hdr_mag_i  (hdr_mag_i),
      .mag_err_i  (hdr_err_i[E_MAG]),
      .match_i    (match),
      .hold_i     (req[c].hold),
      .restart_i  (restart[c]),
      .freeze_i   (freeze[c]),
      .capture_o  (capture_o[c]),
      .found_n_o  (found_n_o[c]),
      .looking_o  (looking_o[c])
    );
  end
endmodule

// File: rtl/ttx_page_matcher_chk.sv
module ttx_page_matcher_chk #(
  parameter int NUM_CIRC = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_data_we_i,
  input logic                hdr_valid_i,
  input logic [6:0]          hdr_err_i,
  input logic [NUM_CIRC-1:0] capture_o,
  input logic [NUM_CIRC-1:0] found_n_o,
  input logic [NUM_CIRC-1:0] looking_o
);
  // R7
  cap_implies_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o & found_n_o) == '0);

  // R7
  look_implies_unfound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (looking_o & ~found_n_o) == '0);

  // R9
  cap_rise_clean_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(capture_o & ~$past(capture_o)) |-> $past(hdr_valid_i && !hdr_err_i[0]));

  // R6
  cap_change_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o != $past(capture_o)) |-> $past(hdr_valid_i || req_data_we_i));

  // R7
  found_fall_by_hdr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(~found_n_o & $past(found_n_o)) |-> $past(hdr_valid_i));
endmodule

bind ttx_page_matcher ttx_page_matcher_chk #(.NUM_CIRC(NUM_CIRC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_data_we_i(req_data_we_i),
  .hdr_valid_i  (hdr_valid_i),
  .hdr_err_i    (hdr_err_i),
  .capture_o    (capture_o),
  .found_n_o    (found_n_o),
  .looking_o    (looking_o)
);

// File: tb/sim_ttx_page_matcher.sv
`timescale 1ns/1ps
module sim_ttx_page_matcher;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_we = 1'b0;
  logic [2:0] a_col = '0;
  logic [1:0] a_circ = '0;
  logic       d_we = 1'b0;
  logic [7:0] d_byte = '0;
  logic       hv = 1'b0;
  logic [2:0] h_mag = '0;
  logic [3:0] h_pt = '0, h_pu = '0, h_hu = '0, h_mu = '0;
  logic [1:0] h_ht = '0;
  logic [2:0] h_mt = '0;
  logic [6:0] h_err = '0;
  logic [3:0] cap, fn, lk;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ttx_page_matcher u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_addr_we_i(a_we), .req_col_i(a_col), .req_circ_i(a_circ),
    .req_data_we_i(d_we), .req_data_i(d_byte),
    .hdr_valid_i(hv), .hdr_mag_i(h_mag), .hdr_pt_i(h_pt), .hdr_pu_i(h_pu),
    .hdr_ht_i(h_ht), .hdr_hu_i(h_hu), .hdr_mt_i(h_mt), .hdr_mu_i(h_mu),
    .hdr_err_i(h_err),
    .capture_o(cap), .found_n_o(fn), .looking_o(lk)
  );

  // behavioural reference
  int  rq [4][7];
  int  p_col, p_circ;
  bit  m_cap [4];
  int  m_mag [4];
  bit  m_fn [4];
  bit  m_lk [4];

  function automatic bit ref_match(int c);
    int dig [7];
    int msk [7];
    dig = '{int'(h_mag), int'(h_pt), int'(h_pu), int'(h_ht), int'(h_hu), int'(h_mt), int'(h_mu)};
    msk = '{7, 15, 15, 3, 15, 7, 15};
    for (int k = 0; k < 7; k++) begin
      if ((rq[c][k] & 16) != 0) begin
        if (h_err[k]) return 0;
        if ((rq[c][k] & msk[k]) != dig[k]) return 0;
      end
    end
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        for (int k = 0; k < 7; k++) rq[c][k] = 0;
        m_cap[c] = 0; m_mag[c] = 0; m_fn[c] = 1; m_lk[c] = 0;
      end
      p_col = 0; p_circ = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        bit col0w;
        col0w = d_we && p_circ == c && p_col == 0;
        if (col0w && d_byte[3]) begin
          m_cap[c] = 0; m_fn[c] = 1; m_lk[c] = 1;
        end else if (col0w) begin
          m_cap[c] = 0; m_lk[c] = 0;
        end else if (hv && !h_err[0]) begin
          if (ref_match(c) && (rq[c][0] & 8) != 0) begin
            m_cap[c] = 1; m_mag[c] = h_mag; m_fn[c] = 0; m_lk[c] = 0;
          end else if (m_cap[c] && m_mag[c] == int'(h_mag)) begin
            m_cap[c] = 0;
          end
        end
      end
      if (d_we && p_col < 7) rq[p_circ][p_col] = d_byte & 8'h1F;
      if (a_we) begin
        p_col = a_col; p_circ = a_circ;
      end else if (d_we) begin
        if (p_col >= 6) begin p_col = 0; p_circ = (p_circ + 1) % 4; end
        else p_col = p_col + 1;
      end
    end
  end

  function automatic logic [3:0] pack(bit v [4]);
    return {v[3], v[2], v[1], v[0]};
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      total += 3;
      if (cap !== pack(m_cap)) begin
        bad++; $display("FAIL R6 model capture act=%b exp=%b", cap, pack(m_cap));
      end
      if (fn !== pack(m_fn)) begin
        bad++; $display("FAIL R7 model found_n act=%b exp=%b", fn, pack(m_fn));
      end
      if (lk !== pack(m_lk)) begin
        bad++; $display("FAIL R7 model looking act=%b exp=%b", lk, pack(m_lk));
      end
    end
  end

  task automatic expect4(string tag, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic set_ptr(int circ, int col);
    a_we = 1'b1; a_circ = 2'(circ); a_col = 3'(col);
    @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic wr(logic [7:0] b);
    d_we = 1'b1; d_byte = b;
    @(negedge clk);
    d_we = 1'b0;
  endtask

  task automatic hdr(int mag, int pt, int pu, int ht, int hu, int mt, int mu, logic [6:0] err);
    hv = 1'b1;
    h_mag = 3'(mag); h_pt = 4'(pt); h_pu = 4'(pu); h_ht = 2'(ht);
    h_hu = 4'(hu); h_mt = 3'(mt); h_mu = 4'(mu); h_err = err;
    @(negedge clk);
    hv = 1'b0; h_err = '0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect4("R1 capture", cap, 4'b0000);
    expect4("R1 found_n", fn, 4'b1111);
    expect4("R1 looking", lk, 4'b0000);
    hdr(1, 0, 0, 0, 0, 0, 0, '0);
    expect4("R1 zero table no capture", cap, 4'b0000);

    // circuit 0: page 1/0/0, circuit 1 via wrap: page 2/3/5
    set_ptr(0, 0);
    wr(8'h19); wr(8'h10); wr(8'h10); wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h00);
    wr(8'h1A); wr(8'h13); wr(8'h15); wr(8'h00); wr(8'h00); wr(8'h00); wr(8'h00);
    expect4("R7 looking after restart", lk, 4'b0011);
    expect4("R7 found_n after restart", fn, 4'b1111);

    hdr(1, 0, 0, 0, 0, 0, 0, '0);
    expect4("R6 capture on match", cap, 4'b0001);
    expect4("R7 found_n on capture", fn, 4'b1110);
    expect4("R7 looking on capture", lk, 4'b0010);

    hdr(2, 3, 5, 0, 0, 0, 0, '0);
    expect4("R2 wrapped entry captures", cap, 4'b0011);

    hdr(3, 0, 0, 0, 0, 0, 0, '0);
    expect4("R6 other magazine keeps", cap, 4'b0011);

    hdr(1, 0, 1, 0, 0, 0, 0, '0);
    expect4("R6 same magazine ends", cap, 4'b0010);
    expect4("R6 found kept", fn, 4'b1100);

    hdr(1, 0, 0, 0, 0, 0, 0, 7'b0000100);
    expect4("R5 cared digit error", cap, 4'b0010);

    hdr(1, 0, 0, 0, 9, 0, 0, 7'b0010000);
    expect4("R5 uncared digit error", cap, 4'b0011);

    hdr(1, 5, 5, 0, 0, 0, 0, 7'b0000001);
    expect4("R9 magazine error ignored", cap, 4'b0011);

    // circuit 2: timed page, magazine 4 at 12:34
    set_ptr(2, 0);
    wr(8'h1C); wr(8'h00); wr(8'h00); wr(8'h11); wr(8'h12); wr(8'h13); wr(8'h14);
    expect4("R7 looking circuit 2", lk, 4'b0100);
    hdr(4, 7, 7, 1, 2, 3, 5, '0);
    expect4("R3 time mismatch", cap, 4'b0011);
    hdr(4, 9, 9, 1, 2, 3, 4, '0);
    expect4("R3 time match any page", cap, 4'b0111);
    expect4("R3 found circuit 2", fn, 4'b1000);

    // freeze circuit 0
    set_ptr(0, 0);
    wr(8'h11);
    expect4("R4 freeze ends capture", cap, 4'b0110);
    expect4("R4 freeze keeps found", fn, 4'b1000);
    hdr(1, 0, 0, 0, 0, 0, 0, '0);
    expect4("R4 held page not retaken", cap, 4'b0110);

    // end circuit 1 capture, then program circuit 3 from column 1
    hdr(2, 0, 0, 0, 0, 0, 0, '0);
    expect4("R6 circuit 1 ends", cap, 4'b0100);
    set_ptr(3, 1);
    wr(8'h13); wr(8'h15);
    set_ptr(3, 0);
    wr(8'h1A);
    expect4("R2 start column looking", lk, 4'b1000);
    hdr(2, 3, 5, 0, 0, 0, 0, '0);
    expect4("R8 two circuits at once", cap, 4'b1110);
    expect4("R8 found both", fn, 4'b0000);

    // column 7 write dropped, pointer moves to circuit 2 column 0
    set_ptr(1, 7);
    wr(8'hFF);
    expect4("R2 column 7 no effect", lk, 4'b0000);
    wr(8'h1D);
    expect4("R7 restart drops capture", cap, 4'b1010);
    expect4("R7 restart looking", lk, 4'b0100);
    expect4("R7 restart found_n", fn, 4'b0100);
    hdr(5, 9, 9, 1, 2, 3, 4, '0);
    expect4("R2 circuit 2 new magazine", cap, 4'b1110);
    hdr(2, 3, 5, 0, 0, 0, 0, '0);
    expect4("R2 circuit 1 table intact", cap, 4'b1110);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule